// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Emulator

This block behaves as the target side of a three-wire synchronous serial nonvolatile memory holding 64 words of 16 bits. It samples chip select, shift clock and serial data in with the fast system clock. Each input goes through a synchronizer, and edges are detected in the system-clock domain. Framed instructions are decoded and act on a register-based array.

Seven operations are available. Read works at any time. Single-word write and erase, whole-array write and erase, and programming enable and disable are the others. A power-up-cleared enable latch gates every operation that changes the array. A counter of system-clock cycles stands in for the nonvolatile programming delay.

A host can poll completion. It drops chip select briefly and raises it again, and serial data out then shows busy (0) or ready (1). A separate output-enable signal models the high-impedance state of data out.

Top module: `w3_eeprom_emul`

## Requirements
- R1: While chip select is high, zeros sampled before the first 1 are ignored. The first sampled 1 is the start bit. It is followed by a 2-bit opcode and a 6-bit word address, both MSB first, with data in sampled on rising shift-clock edges.
- R2: Opcode 10 is read. On the rising edge that samples the last address bit, data out drives a 0 dummy bit. Each following rising edge then presents the next bit of the addressed word, MSB first.
- R3: After reset the array holds all ones and the programming-enable latch is clear. Write, erase, write-all and erase-all leave the array unchanged while the latch is clear.
- R4: Opcode 00 selects an extended operation from the top two address bits: 11 sets the enable latch, 00 clears it, 10 is erase-all and 01 is write-all. The low four address bits are ignored.
- R5: Opcode 01 (write) and the write-all operation take 16 data bits, MSB first, after the address. They replace the stored contents, with no prior erase needed.
- R6: Opcode 11 (erase) sets the addressed word to 0xFFFF, and erase-all sets every word to 0xFFFF. Both start as soon as the address is received.
- R7: If chip select rises while a programming cycle runs, output enable goes high and data out shows 0 while busy, then 1 once the cycle ends. If chip select rises after the cycle has ended, output enable stays low.
- R8: Output enable is low whenever the synchronized chip select is low, including when a read is cut short.
- R9: A start bit received while a programming cycle runs is ignored, together with the rest of its frame.
- R10: A write or write-all whose frame ends (chip select falls) before all 16 data bits arrive leaves the array unchanged.
- R11: The programming cycle lasts PROG_CYCLES system-clock cycles. It begins at the edge that completes the instruction.
- R12: Read returns stored data whether the enable latch is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| cs_i | input | 1 | Chip select, active high, frames an instruction |
| sck_i | input | 1 | Serial shift clock |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out (read data, dummy bit or ready/busy status) |
| dout_oe_o | output | 1 | Output enable for data out; low means high impedance |

## Verification
The hardest situations to reach are those tied to the programming cycle: the status window and the dropping of instructions that arrive while busy. Both need chip select to be toggled, or a whole new frame sent, inside a bounded window after the completing edge. The bench shortens the cycle to a value close to the length of one write frame. A second write frame sent straight after the first then has its start bit land inside the cycle. Status is sampled at fixed offsets, shortly before and shortly after the expected end of the cycle, so that both busy and ready are observed and the cycle length is bounded from both sides.

// File: rtl/w3e_pkg.sv
package w3e_pkg;
  typedef enum logic [1:0] {
    OP_EXT = 2'b00,
    OP_WR  = 2'b01,
    OP_RD  = 2'b10,
    OP_ER  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    EXT_DIS   = 2'b00,
    EXT_WRALL = 2'b01,
    EXT_ERALL = 2'b10,
    EXT_EN    = 2'b11
  } ext_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_RD,
    ST_DAT,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/w3e_sync.sv
module w3e_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/w3e_prog_timer.sv
module w3e_prog_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && cnt_q == CNT_W'(CYCLES)));

  assert_busy_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/w3e_store.sv
module w3e_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_one_i,
  input  logic              we_all_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (we_all_i || (we_one_i && waddr_i == ADDR_W'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_fill_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_all_i |=> (mem_q[0] == $past(wdata_i) && mem_q[DEPTH-1] == $past(wdata_i)));

  assert_one_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_one_i && !we_all_i) |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/w3_eeprom_emul.sv
module w3_eeprom_emul
  import w3e_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic din_i,
  output logic dout_o,
  output logic dout_oe_o
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(((WORD_W > HDR_W) ? WORD_W : HDR_W) + 1);

  logic s_cs, s_sck, s_din, p_cs, p_sck;
  logic cs_rise, cs_fall, sck_rise;

  w3e_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, sck_i, din_i}),
    .q_o   ({s_cs, s_sck, s_din})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_cs  <= 1'b0;
      p_sck <= 1'b0;
    end else begin
      p_cs  <= s_cs;
      p_sck <= s_sck;
    end
  end

  assign cs_rise  = s_cs & ~p_cs;
  assign cs_fall  = ~s_cs & p_cs;
  assign sck_rise = s_sck & ~p_sck & s_cs;

  st_e               st_q;
  logic [HDR_W-1:0]  hdr_q, hdr_next;
  logic [WORD_W-1:0] data_q, data_next, out_sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q, hdr_addr;
  logic              dout_q, stat_q, en_q, all_q;
  logic              busy;
  op_e               op;
  ext_e              ext;
  logic              hdr_done, dat_done;
  logic              er_one, er_all, wr_one, wr_all;
  logic              we_one, we_all, start;
  logic [WORD_W-1:0] wdata, rdata;
  logic [ADDR_W-1:0] waddr;

  assign hdr_next  = {hdr_q[HDR_W-2:0], s_din};
  assign data_next = {data_q[WORD_W-2:0], s_din};
  assign op        = op_e'(hdr_next[HDR_W-1 -: 2]);
  assign hdr_addr  = hdr_next[ADDR_W-1:0];
  assign ext       = ext_e'(hdr_addr[ADDR_W-1 -: 2]);

  assign hdr_done = (st_q == ST_HDR) && sck_rise && (cnt_q == CNT_W'(HDR_W - 1));
  assign dat_done = (st_q == ST_DAT) && sck_rise && (cnt_q == CNT_W'(WORD_W - 1));

  assign er_one = hdr_done && (op == OP_ER) && en_q;
  assign er_all = hdr_done && (op == OP_EXT) && (ext == EXT_ERALL) && en_q;
  assign wr_one = dat_done && !all_q && en_q;
  assign wr_all = dat_done && all_q && en_q;

  assign we_one = er_one | wr_one;
  assign we_all = er_all | wr_all;
  assign start  = we_one | we_all;
  assign wdata  = (er_one | er_all) ? '1 : data_next;
  assign waddr  = hdr_done ? hdr_addr : addr_q;

  w3e_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_one_i(we_one),
    .we_all_i(we_all),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (hdr_addr),
    .rdata_o (rdata)
  );

  w3e_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      hdr_q    <= '0;
      data_q   <= '0;
      out_sr_q <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
      dout_q   <= 1'b0;
      stat_q   <= 1'b0;
      en_q     <= 1'b0;
      all_q    <= 1'b0;
    end else if (cs_fall) begin
      st_q   <= ST_IDLE;
      stat_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cs_rise) begin
          st_q   <= ST_START;
          stat_q <= busy;
        end
        ST_START: if (sck_rise && s_din) begin
          if (busy) st_q <= ST_SKIP;  // instruction dropped while programming
          else begin
            st_q   <= ST_HDR;
            stat_q <= 1'b0;
            hdr_q  <= '0;
            cnt_q  <= '0;
          end
        end
        ST_HDR: if (sck_rise) begin
          hdr_q <= hdr_next;
          cnt_q <= cnt_q + 1'b1;
          if (hdr_done) begin
            st_q <= ST_SKIP;
            unique case (op)
              OP_RD: begin
                st_q     <= ST_RD;
                dout_q   <= 1'b0;  // dummy bit
                out_sr_q <= rdata;
              end
              OP_WR: begin
                st_q   <= ST_DAT;
                addr_q <= hdr_addr;
                all_q  <= 1'b0;
                cnt_q  <= '0;
              end
              OP_ER: ;
              OP_EXT: begin
                unique case (ext)
                  EXT_EN:  en_q <= 1'b1;
                  EXT_DIS: en_q <= 1'b0;
                  EXT_WRALL: begin
                    st_q  <= ST_DAT;
                    all_q <= 1'b1;
                    cnt_q <= '0;
                  end
                  EXT_ERALL: ;
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
        end
        ST_RD: if (sck_rise) begin
          dout_q   <= out_sr_q[WORD_W-1];
          out_sr_q <= {out_sr_q[WORD_W-2:0], 1'b0};
        end
        ST_DAT: if (sck_rise) begin
          data_q <= data_next;
          cnt_q  <= cnt_q + 1'b1;
          if (dat_done) st_q <= ST_SKIP;
        end
        ST_SKIP: ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dout_oe_o = s_cs & (stat_q | (st_q == ST_RD));
  assign dout_o    = stat_q ? ~busy : dout_q;

  assert_prog_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_one | we_all) |-> en_q);

  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !dout_oe_o);

  assert_dummy_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_RD) |-> (dout_oe_o && !dout_o));

  assert_ready_shown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && s_cs && $fell(busy)) |-> (dout_oe_o && dout_o));
endmodule

// File: tb/w3_eeprom_emul_bench.sv
module w3_eeprom_emul_bench;
  localparam int P = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  w3_eeprom_emul #(.PROG_CYCLES(P)) u_w3_eeprom_emul (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cs_i     (cs),
    .sck_i    (sck),
    .din_i    (din),
    .dout_o   (dout),
    .dout_oe_o(dout_oe)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    din = b;
    wait_cyc(2);
    sck = 1'b1;
    wait_cyc(4);
    sck = 1'b0;
    wait_cyc(2);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic frame_open();
    cs = 1'b1;
    wait_cyc(4);
  endtask

  task automatic frame_close();
    sck = 1'b0;
    cs  = 1'b0;
    wait_cyc(6);
  endtask

  task automatic instr(input logic [1:0] op, input logic [5:0] a);
    pulse(1'b1);
    send({14'd0, op}, 2);
    send({10'd0, a}, 6);
  endtask

  task automatic wait_prog();
    wait_cyc(P + 40);
  endtask

  task automatic read_word(input logic [5:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] got;
    frame_open();
    instr(2'b10, a);
    chk(dout_oe && dout == 1'b0, {tag, " R2 dummy"}, {14'd0, dout_oe, dout}, 16'h0002);
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0);
      got[i] = dout;
    end
    frame_close();
    chk(got == exp, tag, got, exp);
  endtask

  task automatic write_word(input logic [5:0] a, input logic [15:0] d);
    frame_open();
    instr(2'b01, a);
    send(d, 16);
    frame_close();
  endtask

  task automatic ext_op(input logic [5:0] a);
    frame_open();
    instr(2'b00, a);
    frame_close();
  endtask

  task automatic t_reset();
    chk(dout_oe == 1'b0, "R8 reset oe", {15'd0, dout_oe}, 16'h0000);
    read_word(6'd0, 16'hFFFF, "R3 reset array");
  endtask

  task automatic t_disabled_write();
    write_word(6'd5, 16'h1234);
    wait_prog();
    read_word(6'd5, 16'hFFFF, "R3/R12 write while disabled");
    frame_open();
    instr(2'b11, 6'd5);
    frame_close();
    wait_cyc(4);
    cs = 1'b1;
    wait_cyc(6);
    chk(dout_oe == 1'b0, "R3 no cycle when disabled", {15'd0, dout_oe}, 16'h0000);
    cs = 1'b0;
    wait_cyc(6);
  endtask

  task automatic t_enable_write();
    ext_op(6'b11_1010);  // R4 low bits nonzero
    write_word(6'd5, 16'hA5C3);
    wait_prog();
    read_word(6'd5, 16'hA5C3, "R4/R5/R2 write then read");
  endtask

  task automatic t_status();
    frame_open();
    instr(2'b01, 6'd12);
    send(16'h0F0F, 16);
    cs = 1'b0;
    wait_cyc(4);
    cs = 1'b1;
    wait_cyc(6);
    chk(dout_oe && dout == 1'b0, "R7 busy shown", {14'd0, dout_oe, dout}, 16'h0002);
    wait_cyc(P);
    chk(dout_oe && dout == 1'b1, "R7 ready shown", {14'd0, dout_oe, dout}, 16'h0003);
    cs = 1'b0;
    wait_cyc(4);
    chk(dout_oe == 1'b0, "R8 oe after cs low", {15'd0, dout_oe}, 16'h0000);
    cs = 1'b1;
    wait_cyc(6);
    chk(dout_oe == 1'b0, "R7 no status after cycle", {15'd0, dout_oe}, 16'h0000);
    frame_close();
    read_word(6'd12, 16'h0F0F, "R5 status word");
  endtask

  task automatic t_leading_zero();
    frame_open();
    pulse(1'b0);
    pulse(1'b0);
    pulse(1'b0);
    instr(2'b01, 6'd33);
    send(16'h8001, 16);
    frame_close();
    wait_prog();
    read_word(6'd33, 16'h8001, "R1 leading zeros");
  endtask

  task automatic t_erase_timing();
    frame_open();
    instr(2'b11, 6'd5);
    cs = 1'b0;
    wait_cyc(4);
    cs = 1'b1;
    wait_cyc(4);
    wait_cyc(P - 24);
    chk(dout_oe && dout == 1'b0, "R11 still busy", {14'd0, dout_oe, dout}, 16'h0002);
    wait_cyc(20);
    chk(dout_oe && dout == 1'b1, "R11 done", {14'd0, dout_oe, dout}, 16'h0003);
    frame_close();
    read_word(6'd5, 16'hFFFF, "R6 erase word");
  endtask

  task automatic t_all_ops();
    frame_open();
    instr(2'b00, 6'b01_0110);
    send(16'h3C96, 16);
    frame_close();
    wait_prog();
    read_word(6'd0, 16'h3C96, "R5 write-all word 0");
    read_word(6'd63, 16'h3C96, "R5 write-all word 63");
    ext_op(6'b10_0001);
    wait_prog();
    read_word(6'd40, 16'hFFFF, "R6 erase-all");
  endtask

  task automatic t_abort();
    write_word(6'd9, 16'h0000);
    wait_prog();
    frame_open();
    instr(2'b01, 6'd9);
    send(16'h00AA, 8);
    frame_close();
    wait_prog();
    read_word(6'd9, 16'h0000, "R10 short write");
    frame_open();
    instr(2'b00, 6'b01_0000);
    send(16'h0055, 10);
    frame_close();
    wait_prog();
    read_word(6'd9, 16'h0000, "R10 short write-all");
  endtask

  task automatic t_busy_ignore();
    write_word(6'd7, 16'h1111);
    write_word(6'd7, 16'h2222);
    wait_prog();
    read_word(6'd7, 16'h1111, "R9 ignored while busy");
  endtask

  task automatic t_cut_read();
    frame_open();
    instr(2'b10, 6'd7);
    pulse(1'b0);
    pulse(1'b0);
    chk(dout_oe == 1'b1, "R8 oe during read", {15'd0, dout_oe}, 16'h0001);
    cs = 1'b0;
    wait_cyc(4);
    chk(dout_oe == 1'b0, "R8 oe cut read", {15'd0, dout_oe}, 16'h0000);
    wait_cyc(4);
  endtask

  task automatic t_disable();
    ext_op(6'b00_0101);
    write_word(6'd7, 16'hDEAD);
    wait_prog();
    read_word(6'd7, 16'h1111, "R4/R3/R12 after disable");
    ext_op(6'b10_0000);
    wait_prog();
    read_word(6'd7, 16'h1111, "R3 erase-all disabled");
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_disabled_write();
    t_enable_write();
    t_status();
    t_leading_zero();
    t_erase_timing();
    t_all_ops();
    t_abort();
    t_busy_ignore();
    t_cut_read();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule